// File: doc/BRIEF.md
# Cartridge RAM Port Address Decoder

This block decodes accesses into a 4 KB cartridge address window. The lowest part of the window holds a small RAM, and every RAM byte appears twice: once in a read port and once in a write port. A parameter chooses whether the write port is the lower or the upper copy. Everything above the RAM area is a ROM region.

Accesses that use the wrong port have defined side effects. A read from the write port stores whatever is on the data bus and returns that value. A write to the read port leaves the RAM alone, but it raises a sticky error flag and captures the address. A synchronous clear resets the flag and the captured address and keeps the RAM contents.

The ROM contents are a fixed computed pattern, so the block needs no external image. The data bus is one byte wide.

Top module: `cart_port_decoder`

## Requirements
- R1: With `WP_HIGH`=1, addresses `RAM_BYTES`..2*`RAM_BYTES`-1 form the write port and 0..`RAM_BYTES`-1 form the read port. With `WP_HIGH`=0 the two halves swap. A write to the write port stores `wdata` at index `addr & (RAM_BYTES-1)`, and a later read of the read port at the same index returns that byte.
- R2: Read data is registered. `rdata` shows the result of an access from the clock edge that samples the access until the next edge.
- R3: A write (`cs`=1, `we`=1) to the read port does not change RAM and keeps `ram_we` low. From the next cycle on, `err_flag` is 1 and `err_addr` holds the offending address.
- R4: A read (`cs`=1, `we`=0) from the write port stores `wdata` into RAM at the masked index, drives `ram_we` high, and returns `wdata` as the read data.
- R5: A read at or above 2*`RAM_BYTES` returns ROM byte `i[7:0] ^ {i[11:8], i[11:8]} ^ 8'hA5`, where `i = addr & (2**ROM_AW - 1)`. A write to this region changes nothing and flags nothing.
- R6: `clr_err`=1 clears `err_flag` and `err_addr` to 0 on the next edge, and RAM keeps its contents. If an illegal write arrives in the same cycle, the new error is recorded instead.
- R7: While `cs`=0 there is no RAM access, `rdata` becomes 0 on the next edge, and the error state does not change unless `clr_err` is high.
- R8: After reset, `rdata`, `err_flag` and `err_addr` are 0.
- R9: `ram_we` is high in a cycle exactly when that cycle commits a RAM write. This is the R1 case or the R4 case.
- R10: After a write cycle of any kind, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| we | input | 1 | 1 = write strobe, 0 = read |
| addr | input | 12 | Offset inside the window |
| wdata | input | 8 | Data bus into the block |
| clr_err | input | 1 | Synchronous clear of the error state |
| rdata | output | 8 | Registered read data |
| ram_we | output | 1 | RAM write commit in this cycle |
| err_flag | output | 1 | Sticky flag for a write to the read port |
| err_addr | output | 12 | Address of the latest write to the read port |

## Verification
The bench builds two instances. The first uses 1 KB of RAM with the write port high and an 11-bit ROM index, so the ROM index wraps at 0x800. The second uses 128 bytes with the write port low and a full 12-bit ROM index. Together they reach both port orders and the edges of both port ranges. They also reach the first and last ROM bytes, a ROM index that wraps, and the boundary between the RAM area and the ROM, which differs between the two instances.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        REG_RD_PORT = 2'd0,
        REG_WR_PORT = 2'd1,
        REG_ROM     = 2'd2
    } region_t;

    typedef enum logic {
        SRC_HOLD = 1'b0,
        SRC_RAM  = 1'b1
    } src_t;

    // Fixed ROM pattern, computed from a 12-bit index
    function automatic byte_t rom_byte(input logic [11:0] idx);
        return idx[7:0] ^ {idx[11:8], idx[11:8]} ^ 8'hA5;
    endfunction

endpackage

// File: rtl/cpd_decode.sv
module cpd_decode
    import cpd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int RAM_BYTES = 1024,
    parameter bit WP_HIGH   = 1'b1,
    parameter int ROM_AW    = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [ADDR_W-1:0] rom_idx
);
    localparam int RAM_AW = $clog2(RAM_BYTES);
    localparam logic [ADDR_W:0] RAM_SPAN = (ADDR_W+1)'(2 * RAM_BYTES);
    localparam logic [ADDR_W-1:0] ROM_MASK = ADDR_W'((1 << ROM_AW) - 1);

    always_comb begin
        if ({1'b0, addr} >= RAM_SPAN)
            region = REG_ROM;
        else if (addr[RAM_AW] == WP_HIGH)
            region = REG_WR_PORT;
        else
            region = REG_RD_PORT;
        rom_idx = addr & ROM_MASK;
    end

endmodule

// File: rtl/cpd_ram.sv
module cpd_ram
    import cpd_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] idx,
    input  byte_t         wr_data,
    output byte_t         rd_q
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wr_data;
        if (rd_en)
            rd_q <= mem[idx];
    end

endmodule

// File: rtl/cart_port_decoder.sv
module cart_port_decoder
    import cpd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int RAM_BYTES = 1024,
    parameter bit WP_HIGH   = 1'b1,
    parameter int ROM_AW    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              clr_err,
    output logic [7:0]        rdata,
    output logic              ram_we,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int RAM_AW = $clog2(RAM_BYTES);

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] bad_addr;
        src_t              src;
        byte_t             hold;
    } state_t;

    state_t    st_d, st_q;
    region_t   region;
    logic [ADDR_W-1:0] rom_idx;
    logic      ram_rd;
    byte_t     ram_q;

    cpd_decode #(
        .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .WP_HIGH(WP_HIGH), .ROM_AW(ROM_AW)
    ) i_decode (
        .addr(addr), .region(region), .rom_idx(rom_idx)
    );

    cpd_ram #(.DEPTH(RAM_BYTES)) i_ram (
        .clk(clk), .wr_en(ram_we), .rd_en(ram_rd),
        .idx(addr[RAM_AW-1:0]), .wr_data(wdata), .rd_q(ram_q)
    );

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        ram_rd = 1'b0;
        st_d.src  = SRC_HOLD;
        st_d.hold = '0;
        if (clr_err) begin
            st_d.flag     = 1'b0;
            st_d.bad_addr = '0;
        end
        if (cs) begin
            if (we) begin
                if (region == REG_WR_PORT) begin
                    ram_we = 1'b1;
                end else if (region == REG_RD_PORT) begin
                    st_d.flag     = 1'b1;
                    st_d.bad_addr = addr;
                end
            end else begin
                unique case (region)
                    REG_RD_PORT: begin
                        ram_rd   = 1'b1;
                        st_d.src = SRC_RAM;
                    end
                    REG_WR_PORT: begin
                        ram_we    = 1'b1;
                        st_d.hold = wdata;
                    end
                    default: st_d.hold = rom_byte(rom_idx[11:0]);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{flag: 1'b0, bad_addr: '0, src: SRC_HOLD, hold: '0};
        else
            st_q <= st_d;
    end

    assign rdata    = (st_q.src == SRC_RAM) ? ram_q : st_q.hold;
    assign err_flag = st_q.flag;
    assign err_addr = st_q.bad_addr;

    // R3: a write to the read port records the address
    a_r3_flag_on_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs && we && region == REG_RD_PORT |=> err_flag && err_addr == $past(addr));

    // R4: a read of the write port returns the bus value
    a_r4_wp_read_echo: assert property (@(posedge clk) disable iff (!rst_n)
        cs && !we && region == REG_WR_PORT |=> rdata == $past(wdata));

    // R6: a clear without a new error empties the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err && !(cs && we && region == REG_RD_PORT) |=> !err_flag && err_addr == '0);

    // R7: an idle cycle keeps the error state and zeroes the read data
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cs && !clr_err |=> $stable(err_flag) && $stable(err_addr) && rdata == '0);

    // R9: a RAM write commits only inside the RAM write port
    a_r9_we_in_port: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> cs && region == REG_WR_PORT);

    // R10: read data is zero after a write cycle
    a_r10_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cs && we |=> rdata == '0);

endmodule

// File: tb/test_cart_port_decoder.sv
module test_cart_port_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // instance A: 1 KB, write port high, ROM index 11 bits
    logic a_cs = 0, a_we = 0, a_clr = 0;
    logic [11:0] a_addr = '0;
    logic [7:0]  a_wd = '0;
    logic [7:0]  a_rd;
    logic        a_rwe, a_ef;
    logic [11:0] a_ea;
    // instance B: 128 bytes, write port low, ROM index 12 bits
    logic b_cs = 0, b_we = 0, b_clr = 0;
    logic [11:0] b_addr = '0;
    logic [7:0]  b_wd = '0;
    logic [7:0]  b_rd;
    logic        b_rwe, b_ef;
    logic [11:0] b_ea;

    cart_port_decoder #(.RAM_BYTES(1024), .WP_HIGH(1'b1), .ROM_AW(11)) i_cart_port_decoder (
        .clk(clk), .rst_n(rst_n), .cs(a_cs), .we(a_we), .addr(a_addr), .wdata(a_wd),
        .clr_err(a_clr), .rdata(a_rd), .ram_we(a_rwe), .err_flag(a_ef), .err_addr(a_ea));

    cart_port_decoder #(.RAM_BYTES(128), .WP_HIGH(1'b0), .ROM_AW(12)) i_cart_port_decoder_low (
        .clk(clk), .rst_n(rst_n), .cs(b_cs), .we(b_we), .addr(b_addr), .wdata(b_wd),
        .clr_err(b_clr), .rdata(b_rd), .ram_we(b_rwe), .err_flag(b_ef), .err_addr(b_ea));

    int n_tests = 0;
    int n_fail  = 0;
    logic we_seen;

    function automatic logic [7:0] exp_rom(input logic [11:0] a, input int aw);
        logic [11:0] i;
        i = a & 12'((1 << aw) - 1);
        return i[7:0] ^ {i[11:8], i[11:8]} ^ 8'hA5;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one access on A, starting and ending at a falling edge
    task automatic step_a(input logic cs, input logic we, input logic [11:0] ad,
                          input logic [7:0] d, input logic clr);
        a_cs = cs; a_we = we; a_addr = ad; a_wd = d; a_clr = clr;
        #(CLK_PERIOD/4);
        we_seen = a_rwe;
        @(negedge clk);
        a_cs = 0; a_we = 0; a_clr = 0;
    endtask

    task automatic step_b(input logic cs, input logic we, input logic [11:0] ad,
                          input logic [7:0] d, input logic clr);
        b_cs = cs; b_we = we; b_addr = ad; b_wd = d; b_clr = clr;
        #(CLK_PERIOD/4);
        we_seen = b_rwe;
        @(negedge clk);
        b_cs = 0; b_we = 0; b_clr = 0;
    endtask

    task automatic t_reset();
        check("R8 rdata", a_rd, 0);
        check("R8 err_flag", a_ef, 0);
        check("R8 err_addr", a_ea, 0);
    endtask

    task automatic t_ports_high();
        step_a(1, 1, 12'h405, 8'h3C, 0); check("R9 ram_we wp write", we_seen, 1);
        check("R10 rdata after write", a_rd, 0);
        step_a(1, 1, 12'h7FF, 8'h81, 0);
        step_a(1, 1, 12'h406, 8'h22, 0);
        step_a(1, 0, 12'h005, 8'h00, 0); check("R1 read idx 5", a_rd, 8'h3C);
        check("R9 no ram_we on rp read", we_seen, 0);
        step_a(1, 0, 12'h3FF, 8'h00, 0); check("R1 read idx 3FF", a_rd, 8'h81);
        // R2: data holds only one cycle, idle then zeroes it
        step_a(0, 0, 12'h3FF, 8'h00, 0); check("R2 one-cycle data", a_rd, 0);
    endtask

    task automatic t_rom_a();
        step_a(1, 0, 12'h800, 8'h00, 0); check("R5 rom first", a_rd, exp_rom(12'h800, 11));
        step_a(1, 0, 12'hFFF, 8'h00, 0); check("R5 rom last", a_rd, exp_rom(12'hFFF, 11));
        step_a(1, 1, 12'h805, 8'h77, 0); check("R5 rom write no ram_we", we_seen, 0);
        check("R5 rom write no flag", a_ef, 0);
        step_a(1, 0, 12'h005, 8'h00, 0); check("R5 ram untouched", a_rd, 8'h3C);
    endtask

    task automatic t_bad_write();
        step_a(1, 1, 12'h005, 8'hEE, 0); check("R3 no ram_we", we_seen, 0);
        check("R3 flag", a_ef, 1);
        check("R3 addr", a_ea, 12'h005);
        step_a(1, 0, 12'h005, 8'h00, 0); check("R3 ram unchanged", a_rd, 8'h3C);
    endtask

    task automatic t_clear();
        step_a(0, 0, 12'h000, 8'h00, 1); check("R6 flag cleared", a_ef, 0);
        check("R6 addr cleared", a_ea, 0);
        step_a(1, 0, 12'h005, 8'h00, 0); check("R6 ram retained", a_rd, 8'h3C);
        step_a(1, 1, 12'h123, 8'h01, 1); check("R6 new error wins", a_ef, 1);
        check("R6 new error addr", a_ea, 12'h123);
    endtask

    task automatic t_wp_read();
        step_a(1, 0, 12'h405, 8'h99, 0); check("R4 ram_we", we_seen, 1);
        check("R4 returns bus", a_rd, 8'h99);
        step_a(1, 0, 12'h005, 8'h00, 0); check("R4 stored", a_rd, 8'h99);
    endtask

    task automatic t_idle();
        step_a(1, 0, 12'h800, 8'h00, 0);
        step_a(0, 1, 12'h406, 8'h11, 0); check("R7 no ram_we", we_seen, 0);
        check("R7 rdata zero", a_rd, 0);
        check("R7 flag held", a_ef, 1);
        check("R7 addr held", a_ea, 12'h123);
        step_a(0, 1, 12'h010, 8'h11, 0); check("R7 no new flag addr", a_ea, 12'h123);
        step_a(1, 0, 12'h006, 8'h00, 0); check("R7 ram untouched", a_rd, 8'h22);
    endtask

    task automatic t_ports_low();
        step_b(1, 1, 12'h07F, 8'h5C, 0); check("R1 B wp write", we_seen, 1);
        step_b(1, 1, 12'h000, 8'hA1, 0);
        step_b(1, 0, 12'h0FF, 8'h00, 0); check("R1 B read top", b_rd, 8'h5C);
        step_b(1, 0, 12'h080, 8'h00, 0); check("R1 B read base", b_rd, 8'hA1);
        step_b(1, 1, 12'h080, 8'h33, 0); check("R3 B flag", b_ef, 1);
        check("R3 B addr", b_ea, 12'h080);
        step_b(1, 0, 12'h100, 8'h00, 0); check("R5 B rom edge", b_rd, exp_rom(12'h100, 12));
        step_b(1, 0, 12'hFFF, 8'h00, 0); check("R5 B rom last", b_rd, exp_rom(12'hFFF, 12));
        step_b(1, 0, 12'h010, 8'h4D, 0); check("R4 B wp read", b_rd, 8'h4D);
        step_b(1, 0, 12'h090, 8'h00, 0); check("R4 B stored", b_rd, 8'h4D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ports_high();
        t_rom_a();
        t_bad_write();
        t_clear();
        t_wp_read();
        t_idle();
        t_ports_low();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule